// File: doc/BRIEF.md
# Cartridge Bank Switcher with Address Hotspots

This block lets an 8-bit host with a 13-line address bus reach a 24 KB program image through a 4 KB cartridge window. The image is split into six 4 KB banks, and only one of them is visible in the window at a time. The host changes banks by touching one of six reserved offsets near the top of the window. The block then turns each host address into the physical image address that program storage is read with.

Address line 12 acts as the cartridge select. Hotspots are decoded only from that line and the low twelve offset bits, so every mirror of the window behaves the same way. Offsets $FF6 to $FFB select banks 0 to 5 in that order. Reset leaves bank 5 active, which is the bank meant to hold the host's own code. Banks 0 to 4 can still be selected freely.

Top module: `cart_bank_mapper`

## Requirements
- R1: In the first cycle after the active-low synchronous reset is released, `curBank` reads 5, and no hotspot access is needed for this.
- R2: When `cycleValid` is high, `hostAddr[12]` is 1 and `hostAddr[11:0]` equals $FF6+k for k in 0..5, `curBank` becomes k at the next rising clock edge.
- R3: A hotspot switches the bank for both reads (`hostWrite`=0) and writes (`hostWrite`=1).
- R4: `imageAddr` equals `curBank`×4096 + `hostAddr[11:0]`, with the bank number in bits 14:12 and the offset in bits 11:0. It is combinational from the current address.
- R5: During the access that hits a hotspot, `imageAddr` still uses the bank that was active before the switch. The new bank applies from the next access onward.
- R6: Offsets $FFC to $FFF, and every other offset outside $FF6 to $FFB, leave `curBank` unchanged and translate through the current bank.
- R7: An access with `hostAddr[12]`=0 never changes `curBank`, even at a hotspot offset, and it holds `imageValid` low.
- R8: While `cycleValid` is low, `curBank` does not change, whatever the address is.
- R9: `imageValid` is 1 exactly when `cycleValid` is 1 and `hostAddr[12]` is 1.
- R10: Any bank can be reached from any other bank, and `curBank` never holds a value above 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 13 | Host address; bit 12 is the cartridge select |
| hostWrite | input | 1 | 1 = host write, 0 = host read |
| cycleValid | input | 1 | Marks one qualified bus cycle, high for one clock per access |
| imageAddr | output | 15 | Physical address into the 24 KB program image |
| imageValid | output | 1 | Translated address is valid (cartridge selected) |
| curBank | output | 3 | Currently active bank, for observation |

## Verification
The bench builds the block with its default parameters. These are a 13-bit host bus, six banks whose hotspots start at offset $FF6, bank 5 after reset, and hotspots armed for both reads and writes. With these values every hotspot is reached by both access kinds and from every starting bank. So are the four vector offsets just above the hotspots and the mirrors with the select line low. Random addresses are biased toward the top sixteen offsets, so that bank changes and the boundary offsets $FF5 and $FFC come up often.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int NUM_BANKS = 6;
  localparam int BANK_W = $clog2(NUM_BANKS);

  typedef struct packed {
    logic               loadBank;
    logic [BANK_W-1:0]  newBank;
  } bank_cmd_t;
endpackage

// File: rtl/cbm_hotspot_ctrl.sv
module cbm_hotspot_ctrl
  import cbm_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int HOT_BASE  = 'hFF6,
  parameter bit HOT_ON_RD = 1'b1,
  parameter bit HOT_ON_WR = 1'b1
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrite,
  input  logic              cycleValid,
  output bank_cmd_t         cmd
);
  localparam int OFFS_W = ADDR_W - 1;

  logic [OFFS_W-1:0]    offset;
  logic [NUM_BANKS-1:0] hit;
  logic                 armed;
  logic [BANK_W-1:0]    hitIdx;

  assign offset = hostAddr[OFFS_W-1:0];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hot
    assign hit[g] = (offset == OFFS_W'(HOT_BASE + g));
  end

  // Pick which access kinds may trigger a switch
  if (HOT_ON_RD && HOT_ON_WR) begin : g_both
    assign armed = 1'b1 | hostWrite;
  end else if (HOT_ON_WR) begin : g_wr
    assign armed = hostWrite;
  end else if (HOT_ON_RD) begin : g_rd
    assign armed = ~hostWrite;
  end else begin : g_none
    assign armed = 1'b0 & hostWrite;
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (hit[i]) hitIdx = BANK_W'(i);
    end
  end

  assign cmd.loadBank = cycleValid & hostAddr[ADDR_W-1] & armed & (|hit);
  assign cmd.newBank  = hitIdx;
endmodule

// File: rtl/cbm_bank_path.sv
module cbm_bank_path
  import cbm_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int RESET_BANK = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic                     cycleValid,
  input  bank_cmd_t                cmd,
  output logic [ADDR_W-2+BANK_W:0] imageAddr,
  output logic                     imageValid,
  output logic [BANK_W-1:0]        curBank
);
  localparam int OFFS_W = ADDR_W - 1;

  logic [BANK_W-1:0] bankReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankReg <= BANK_W'(RESET_BANK);
    end else if (cmd.loadBank) begin
      bankReg <= cmd.newBank;
    end
  end

  // bank x 2^OFFS_W + offset is a plain concatenation
  assign imageAddr  = {bankReg, hostAddr[OFFS_W-1:0]};
  assign imageValid = cycleValid & hostAddr[ADDR_W-1];
  assign curBank    = bankReg;
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int HOT_BASE   = 'hFF6,
  parameter int RESET_BANK = 5,
  parameter bit HOT_ON_RD  = 1'b1,
  parameter bit HOT_ON_WR  = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [12:0] hostAddr,
  input  logic        hostWrite,
  input  logic        cycleValid,
  output logic [14:0] imageAddr,
  output logic        imageValid,
  output logic [2:0]  curBank
);
  bank_cmd_t cmd;

  cbm_hotspot_ctrl #(
    .ADDR_W(ADDR_W), .HOT_BASE(HOT_BASE),
    .HOT_ON_RD(HOT_ON_RD), .HOT_ON_WR(HOT_ON_WR)
  ) u_ctrl (
    .hostAddr(hostAddr), .hostWrite(hostWrite),
    .cycleValid(cycleValid), .cmd(cmd)
  );

  cbm_bank_path #(
    .ADDR_W(ADDR_W), .RESET_BANK(RESET_BANK)
  ) u_path (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr),
    .cycleValid(cycleValid), .cmd(cmd),
    .imageAddr(imageAddr), .imageValid(imageValid), .curBank(curBank)
  );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int HOT_BASE   = 'hFF6,
  parameter int NUM_BANKS  = 6,
  parameter int RESET_BANK = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic [12:0] hostAddr,
  input logic        cycleValid,
  input logic [14:0] imageAddr,
  input logic        imageValid,
  input logic [2:0]  curBank
);
  localparam logic [11:0] HOT_LO = 12'(HOT_BASE);
  localparam logic [11:0] HOT_HI = 12'(HOT_BASE + NUM_BANKS - 1);

  logic wasInReset = 1'b0;
  logic hotHit;

  always_ff @(posedge clk) wasInReset <= !rstN;

  assign hotHit = cycleValid && hostAddr[12] &&
                  (hostAddr[11:0] >= HOT_LO) && (hostAddr[11:0] <= HOT_HI);

  AST_RESET_BANK: assert property (@(posedge clk) disable iff (!rstN)
    wasInReset |-> (curBank == 3'(RESET_BANK)));                          // R1
  AST_HOT_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    hotHit |=> (curBank == 3'($past(hostAddr[11:0]) - HOT_LO)));            // R2
  AST_NO_STRAY_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    !hotHit |=> $stable(curBank));                                          // R6
  AST_XLATE: assert property (@(posedge clk) disable iff (!rstN)
    (imageAddr[11:0] == hostAddr[11:0]) && (imageAddr[14:12] == curBank));  // R4
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !hostAddr[12] |-> !imageValid);                                         // R7
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    curBank < 3'(NUM_BANKS));                                               // R10
endmodule

bind cart_bank_mapper cbm_checker #(
  .HOT_BASE(HOT_BASE), .NUM_BANKS(cbm_pkg::NUM_BANKS), .RESET_BANK(RESET_BANK)
) u_cbm_checker (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .cycleValid(cycleValid),
  .imageAddr(imageAddr), .imageValid(imageValid), .curBank(curBank)
);

// File: tb/cart_bank_mapper_bench.sv
module cart_bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] hostAddr = '0;
  logic        hostWrite = 1'b0;
  logic        cycleValid = 1'b0;
  logic [14:0] imageAddr;
  logic        imageValid;
  logic [2:0]  curBank;

  int testCount = 0;
  int failCount = 0;
  int modelBank = 5;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cart_bank_mapper u_cart_bank_mapper (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrite(hostWrite),
    .cycleValid(cycleValid), .imageAddr(imageAddr), .imageValid(imageValid),
    .curBank(curBank)
  );

  function automatic bit isHot(logic [12:0] a, logic v);
    return v && a[12] && (a[11:0] >= 12'hFF6) && (a[11:0] <= 12'hFFB);
  endfunction

  function automatic int expImage(int bank, logic [12:0] a);
    return bank * 4096 + int'(a[11:0]);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One bus access: compare translation mid-cycle, then bank after the edge
  task automatic access(logic [12:0] a, logic wr, logic v, string req);
    @(negedge clk);
    hostAddr = a; hostWrite = wr; cycleValid = v;
    #1;
    chk(imageAddr == 15'(expImage(modelBank, a)), {req, "/R4/R5 addr"},
        int'(imageAddr), expImage(modelBank, a));
    chk(imageValid == (v & a[12]), {req, "/R9 valid"},
        int'(imageValid), int'(v & a[12]));
    @(posedge clk);
    if (isHot(a, v)) modelBank = int'(a[11:0]) - 'hFF6;
    #1;
    chk(int'(curBank) == modelBank, {req, " bank"}, int'(curBank), modelBank);
    cycleValid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [12:0] a;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk(curBank == 3'd5, "R1 reset bank", int'(curBank), 5);

    // R2 R3: every hotspot as read and as write, from several start banks
    for (int k = 0; k < 6; k++) access(13'h1FF6 + 13'(k), 1'b0, 1'b1, "R2 read");
    for (int k = 5; k >= 0; k--) access(13'h1FF6 + 13'(k), 1'b1, 1'b1, "R3 write");
    // R10: every bank to every bank
    for (int f = 0; f < 6; f++)
      for (int t = 0; t < 6; t++) begin
        access(13'h1FF6 + 13'(f), 1'b0, 1'b1, "R10 from");
        access(13'h1FF6 + 13'(t), 1'b1, 1'b1, "R10 to");
      end
    // R6: vectors and neighbours are plain reads
    access(13'h1FF7, 1'b0, 1'b1, "R6 setup");
    for (int k = 12; k < 16; k++) access(13'h1FF0 + 13'(k), 1'b0, 1'b1, "R6 vector");
    access(13'h1FF5, 1'b1, 1'b1, "R6 below");
    access(13'h1000, 1'b0, 1'b1, "R6 base");
    // R7: select low at hotspot offsets
    for (int k = 0; k < 6; k++) access(13'h0FF6 + 13'(k), 1'b1, 1'b1, "R7 deselect");
    // R8: no strobe
    for (int k = 0; k < 6; k++) access(13'h1FF6 + 13'(k), 1'b0, 1'b0, "R8 idle");
    access(13'h1FFA, 1'b0, 1'b1, "R5 switch");
    access(13'h1ABC, 1'b0, 1'b1, "R5 after");

    // Random mix, biased to the top sixteen offsets
    for (int n = 0; n < 3000; n++) begin
      a = 13'($urandom);
      if ($urandom % 2 == 0) a[11:4] = 8'hFF;
      access(a, 1'($urandom), ($urandom % 4) != 0, "R2/R6/R7/R8 random");
    end

    // R1 again: reset mid-run returns to bank 5
    access(13'h1FF6, 1'b0, 1'b1, "R1 setup");
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    modelBank = 5;
    #1;
    chk(curBank == 3'd5, "R1 re-reset", int'(curBank), 5);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule